// File: doc/BRIEF.md
# Method Front End with Macro Gathering and Dirty Tracking

This block sits at the register interface of a 3D engine and takes one method call per cycle. Each call carries a method number, a 32-bit argument and a count of the words still left in the call, this word included. The block routes each call to one of two paths. The first path handles the macro trigger range, which starts at method 0xE00. An even method in that range opens a macro call. The odd method just above it is that macro's argument port. The block gathers the words of the call and emits a one-cycle launch that carries the macro slot number and the gathered argument list.

Every method below the macro range is an ordinary register write. A write is kept only when its value differs from the value already stored. An actual change in the vertex-attribute-format window raises a single format-dirty flag. An actual change in one of three vertex windows raises the dirty bit of the array it addresses: the array-descriptor window, the array-limit window and the instanced-array window. A clear input drops all dirty state. Two sticky flags report misuse of the macro protocol and overflow of the argument buffer. A read port shows the stored register values.

Top module: `mthd_front`

## Requirements
- R1: After reset, launch_valid, fmt_dirty, every arr_dirty bit, proto_err and ovf_err are 0, and every stored register reads as 0.
- R2: When no macro is open, a call at an even method m >= 0xE00 opens a macro with slot number (m - 0xE00) >> 1. An odd method in that state sets proto_err, is not gathered and launches nothing.
- R3: Every gathered word is appended to the argument list in arrival order. When the word's call_remain is 1 or less, launch_valid is high for exactly the next cycle. In that cycle launch_index holds the slot, launch_argc holds the word count, and argument k appears on launch_args[32k+31:32k].
- R4: While a macro is open, any call whose method is not the open macro method plus one sets proto_err, which stays set until reset. A word in the macro range is still gathered, and an ordinary write is still processed.
- R5: Words beyond ARG_DEPTH are dropped and set ovf_err, which stays set until reset. launch_argc saturates at ARG_DEPTH.
- R6: A launch closes the macro and empties the argument list, so the next even macro method opens a new call without error.
- R7: A call at a macro-range method changes no stored register and no dirty state.
- R8: An ordinary write whose value equals the stored value changes nothing. A write of a different value is stored and can be read back through rd_method/rd_data.
- R9: A change in the array-descriptor window 0x40..0xBF (4 words per array) sets arr_dirty[(m - 0x40) >> 2].
- R10: A change in the array-limit window 0xC0..0xFF (2 words per array) sets arr_dirty[(m - 0xC0) >> 1].
- R11: A change in the instanced-array window 0x100..0x11F sets arr_dirty[m - 0x100].
- R12: A change in the format window 0x10..0x1F sets fmt_dirty.
- R13: dirty_clr clears fmt_dirty and all arr_dirty bits on the next edge. A change written in the same cycle still sets its own bit.
- R14: A write to a method from NUM_REGS (0x120) up to 0xE00 is ignored: it is not stored, it sets no dirty bit, and it reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_valid | input | 1 | A method call is present this cycle |
| call_method | input | METHOD_W (13) | Method number |
| call_arg | input | DATA_W (32) | Argument word |
| call_remain | input | REMAIN_W (16) | Words left in the call, this one included |
| dirty_clr | input | 1 | Clear all dirty state |
| rd_method | input | METHOD_W (13) | Register read address |
| rd_data | output | DATA_W (32) | Stored value at rd_method (combinational) |
| launch_valid | output | 1 | One-cycle macro launch |
| launch_index | output | METHOD_W-1 (12) | Macro slot being launched |
| launch_argc | output | clog2(ARG_DEPTH+1) | Number of gathered arguments |
| launch_args | output | ARG_DEPTH*DATA_W | Gathered arguments, argument 0 in the low word |
| fmt_dirty | output | 1 | Vertex-format state changed |
| arr_dirty | output | NUM_ARRAYS (32) | Per-array dirty bits |
| proto_err | output | 1 | Sticky macro protocol error |
| ovf_err | output | 1 | Sticky argument buffer overflow |

## Verification
The bench builds the block with ARG_DEPTH set to 4 and every other parameter at its default. The smaller buffer lets a six-word macro call exceed the buffer, which exercises both the drop path and the saturating count in a few cycles. The default window layout keeps the first and last array of each vertex window inside the 288-entry register file. Both ends of every window, and the first address past the file, can therefore be tested against the real dirty-bit arithmetic.

// File: rtl/mfront_pkg.sv
package mfront_pkg;

  // True when m falls inside [base, base+span)
  function automatic logic in_win(input int unsigned m, input int unsigned base,
                                  input int unsigned span);
    return (m >= base) && (m < base + span);
  endfunction

  // Element number of m inside a window whose elements are 2**sh words wide
  function automatic int unsigned slot_of(input int unsigned m, input int unsigned base,
                                          input int unsigned sh);
    return (m - base) >> sh;
  endfunction

  // Macro slot addressed by a trigger or argument method
  function automatic int unsigned macro_slot(input int unsigned m, input int unsigned base);
    return (m - base) >> 1;
  endfunction

endpackage

// File: rtl/mfront_macro_gather.sv
module mfront_macro_gather
  import mfront_pkg::*;
#(
  parameter int unsigned METHOD_W   = 13,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned REMAIN_W   = 16,
  parameter int unsigned ARG_DEPTH  = 8,
  parameter int unsigned MACRO_BASE = 32'hE00,
  localparam int unsigned CNT_W     = $clog2(ARG_DEPTH + 1),
  localparam int unsigned IDX_W     = METHOD_W - 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        call_valid,
  input  logic [METHOD_W-1:0]         call_method,
  input  logic [DATA_W-1:0]           call_arg,
  input  logic [REMAIN_W-1:0]         call_remain,
  output logic                        launch_valid,
  output logic [IDX_W-1:0]            launch_index,
  output logic [CNT_W-1:0]            launch_argc,
  output logic [ARG_DEPTH*DATA_W-1:0] launch_args,
  output logic                        proto_err,
  output logic                        ovf_err
);

  logic                exec_q;
  logic [METHOD_W-1:0] cur_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [DATA_W-1:0]   args_q [ARG_DEPTH];
  logic [DATA_W-1:0]   args_n [ARG_DEPTH];
  logic [DATA_W-1:0]   snap_q [ARG_DEPTH];

  // Named decode events
  logic                is_mac, bad_start, take, mismatch, room, append, drop, finish;
  logic [METHOD_W-1:0] head;

  assign is_mac    = call_valid && (32'(call_method) >= MACRO_BASE);
  assign bad_start = is_mac && !exec_q && call_method[0];
  assign take      = is_mac && !bad_start;
  assign mismatch  = call_valid && exec_q && (call_method != cur_q + METHOD_W'(1));
  assign room      = (32'(cnt_q) < ARG_DEPTH);
  assign append    = take && room;
  assign drop      = take && !room;
  assign finish    = take && (call_remain <= REMAIN_W'(1));
  assign head      = exec_q ? cur_q : call_method;

  always_comb begin
    for (int k = 0; k < ARG_DEPTH; k++) begin
      args_n[k] = args_q[k];
      if (append && (cnt_q == CNT_W'(k))) args_n[k] = call_arg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exec_q       <= 1'b0;
      cur_q        <= '0;
      cnt_q        <= '0;
      launch_valid <= 1'b0;
      launch_index <= '0;
      launch_argc  <= '0;
      proto_err    <= 1'b0;
      ovf_err      <= 1'b0;
      for (int k = 0; k < ARG_DEPTH; k++) begin
        args_q[k] <= '0;
        snap_q[k] <= '0;
      end
    end else begin
      proto_err <= proto_err | bad_start | mismatch;
      ovf_err   <= ovf_err | drop;
      for (int k = 0; k < ARG_DEPTH; k++) args_q[k] <= args_n[k];
      if (take && !exec_q) begin
        exec_q <= 1'b1;
        cur_q  <= call_method;
      end
      if (append) cnt_q <= cnt_q + CNT_W'(1);
      launch_valid <= 1'b0;
      if (finish) begin
        exec_q       <= 1'b0;
        cnt_q        <= '0;
        launch_valid <= 1'b1;
        launch_index <= IDX_W'(macro_slot(32'(head), MACRO_BASE));
        launch_argc  <= append ? cnt_q + CNT_W'(1) : cnt_q;
        for (int k = 0; k < ARG_DEPTH; k++) snap_q[k] <= args_n[k];
      end
    end
  end

  for (genvar g = 0; g < ARG_DEPTH; g++) begin : g_pack
    assign launch_args[g*DATA_W +: DATA_W] = snap_q[g];
  end

  // R2: an odd opening word launches nothing
  a_r2_odd_start_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (call_valid && 32'(call_method) >= MACRO_BASE && !exec_q && call_method[0]) |=> !launch_valid);
  // R4: protocol error is sticky
  a_r4_perr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
  // R5: overflow is sticky and the count never exceeds the depth
  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);
  a_r5_argc_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    launch_valid |-> (32'(launch_argc) <= ARG_DEPTH && launch_argc != '0));
  // R6: a launch leaves no macro open
  a_r6_closed_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
    launch_valid |-> (!exec_q && cnt_q == '0));

endmodule

// File: rtl/mfront_reg_store.sv
module mfront_reg_store #(
  parameter int unsigned METHOD_W   = 13,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_REGS   = 288,
  parameter int unsigned MACRO_BASE = 32'hE00,
  localparam int unsigned AW        = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  input  logic [METHOD_W-1:0] wr_method,
  input  logic [DATA_W-1:0]   wr_arg,
  input  logic [METHOD_W-1:0] rd_method,
  output logic [DATA_W-1:0]   rd_data,
  output logic                chg_en,
  output logic [METHOD_W-1:0] chg_method
);

  logic [DATA_W-1:0] mem [NUM_REGS];
  logic              hit;
  logic [AW-1:0]     waddr, raddr;

  assign waddr      = wr_method[AW-1:0];
  assign raddr      = rd_method[AW-1:0];
  assign hit        = wr_valid && (32'(wr_method) < NUM_REGS) && (32'(wr_method) < MACRO_BASE);
  assign chg_en     = hit && (mem[waddr] != wr_arg);
  assign chg_method = wr_method;
  assign rd_data    = (32'(rd_method) < NUM_REGS) ? mem[raddr] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_REGS; k++) mem[k] <= '0;
    end else if (chg_en) begin
      mem[waddr] <= wr_arg;
    end
  end

  // R7: macro-range calls never register a change
  a_r7_macro_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && 32'(wr_method) >= MACRO_BASE) |-> !chg_en);
  // R8: a recorded change leaves the new value in storage
  a_r8_change_lands: assert property (@(posedge clk) disable iff (!rst_n)
    chg_en |=> (mem[$past(waddr)] == $past(wr_arg)));

endmodule

// File: rtl/mfront_dirty_track.sv
module mfront_dirty_track
  import mfront_pkg::*;
#(
  parameter int unsigned METHOD_W   = 13,
  parameter int unsigned FMT_BASE   = 32'h10,
  parameter int unsigned FMT_COUNT  = 16,
  parameter int unsigned ARR_BASE   = 32'h40,
  parameter int unsigned ARR_STRIDE = 4,
  parameter int unsigned LIM_BASE   = 32'hC0,
  parameter int unsigned LIM_STRIDE = 2,
  parameter int unsigned INST_BASE  = 32'h100,
  parameter int unsigned NUM_ARRAYS = 32,
  localparam int unsigned ARR_SH    = $clog2(ARR_STRIDE),
  localparam int unsigned LIM_SH    = $clog2(LIM_STRIDE)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  chg_en,
  input  logic [METHOD_W-1:0]   chg_method,
  input  logic                  dirty_clr,
  output logic                  fmt_dirty,
  output logic [NUM_ARRAYS-1:0] arr_dirty
);

  logic [NUM_ARRAYS-1:0] set_vec;
  logic                  fmt_set;
  logic                  in_arr, in_lim, in_inst;
  int unsigned           m;

  assign m       = 32'(chg_method);
  assign in_arr  = in_win(m, ARR_BASE, NUM_ARRAYS * ARR_STRIDE);
  assign in_lim  = in_win(m, LIM_BASE, NUM_ARRAYS * LIM_STRIDE);
  assign in_inst = in_win(m, INST_BASE, NUM_ARRAYS);
  assign fmt_set = chg_en && in_win(m, FMT_BASE, FMT_COUNT);

  for (genvar a = 0; a < NUM_ARRAYS; a++) begin : g_arr
    assign set_vec[a] = chg_en && (
        (in_arr && slot_of(m, ARR_BASE, ARR_SH) == a) ||
        (!in_arr && in_lim && slot_of(m, LIM_BASE, LIM_SH) == a) ||
        (!in_arr && !in_lim && in_inst && slot_of(m, INST_BASE, 0) == a));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arr_dirty <= '0;
      fmt_dirty <= 1'b0;
    end else begin
      arr_dirty <= (dirty_clr ? '0 : arr_dirty) | set_vec;
      fmt_dirty <= (dirty_clr ? 1'b0 : fmt_dirty) | fmt_set;
    end
  end

  // R13: a clear with no change empties all dirty state
  a_r13_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_clr && !chg_en) |=> (arr_dirty == '0 && !fmt_dirty));
  // R8: without a change or clear the dirty state holds
  a_r8_quiet_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg_en && !dirty_clr) |=> ($stable(arr_dirty) && $stable(fmt_dirty)));
  // R9: at most one array bit is raised per change
  a_r9_single_set: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec));

endmodule

// File: rtl/mthd_front.sv
module mthd_front #(
  parameter int unsigned METHOD_W   = 13,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned REMAIN_W   = 16,
  parameter int unsigned ARG_DEPTH  = 8,
  parameter int unsigned MACRO_BASE = 32'hE00,
  parameter int unsigned NUM_REGS   = 288,
  parameter int unsigned FMT_BASE   = 32'h10,
  parameter int unsigned FMT_COUNT  = 16,
  parameter int unsigned ARR_BASE   = 32'h40,
  parameter int unsigned LIM_BASE   = 32'hC0,
  parameter int unsigned INST_BASE  = 32'h100,
  parameter int unsigned NUM_ARRAYS = 32,
  localparam int unsigned CNT_W     = $clog2(ARG_DEPTH + 1),
  localparam int unsigned IDX_W     = METHOD_W - 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        call_valid,
  input  logic [METHOD_W-1:0]         call_method,
  input  logic [DATA_W-1:0]           call_arg,
  input  logic [REMAIN_W-1:0]         call_remain,
  input  logic                        dirty_clr,
  input  logic [METHOD_W-1:0]         rd_method,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        launch_valid,
  output logic [IDX_W-1:0]            launch_index,
  output logic [CNT_W-1:0]            launch_argc,
  output logic [ARG_DEPTH*DATA_W-1:0] launch_args,
  output logic                        fmt_dirty,
  output logic [NUM_ARRAYS-1:0]       arr_dirty,
  output logic                        proto_err,
  output logic                        ovf_err
);

  logic                chg_en;
  logic [METHOD_W-1:0] chg_method;

  mfront_macro_gather #(
    .METHOD_W(METHOD_W), .DATA_W(DATA_W), .REMAIN_W(REMAIN_W),
    .ARG_DEPTH(ARG_DEPTH), .MACRO_BASE(MACRO_BASE)
  ) u_gather (
    .clk(clk), .rst_n(rst_n), .call_valid(call_valid), .call_method(call_method),
    .call_arg(call_arg), .call_remain(call_remain), .launch_valid(launch_valid),
    .launch_index(launch_index), .launch_argc(launch_argc), .launch_args(launch_args),
    .proto_err(proto_err), .ovf_err(ovf_err)
  );

  mfront_reg_store #(
    .METHOD_W(METHOD_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .MACRO_BASE(MACRO_BASE)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_valid(call_valid), .wr_method(call_method),
    .wr_arg(call_arg), .rd_method(rd_method), .rd_data(rd_data),
    .chg_en(chg_en), .chg_method(chg_method)
  );

  mfront_dirty_track #(
    .METHOD_W(METHOD_W), .FMT_BASE(FMT_BASE), .FMT_COUNT(FMT_COUNT),
    .ARR_BASE(ARR_BASE), .ARR_STRIDE(4), .LIM_BASE(LIM_BASE), .LIM_STRIDE(2),
    .INST_BASE(INST_BASE), .NUM_ARRAYS(NUM_ARRAYS)
  ) u_dirty (
    .clk(clk), .rst_n(rst_n), .chg_en(chg_en), .chg_method(chg_method),
    .dirty_clr(dirty_clr), .fmt_dirty(fmt_dirty), .arr_dirty(arr_dirty)
  );

  // R14: writes above the register file raise no dirty state
  a_r14_beyond_file_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (call_valid && 32'(call_method) >= NUM_REGS && !dirty_clr) |=>
      ($stable(arr_dirty) && $stable(fmt_dirty)));

endmodule

// File: tb/mthd_front_bench.sv
module mthd_front_bench;
  localparam int DEPTH = 4;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 0;
  always #4 clk = ~clk;

  logic rst_n = 0, call_valid = 0, dirty_clr = 0;
  logic [12:0] call_method = 0, rd_method = 0;
  logic [31:0] call_arg = 0, rd_data;
  logic [15:0] call_remain = 0;
  logic launch_valid, fmt_dirty, proto_err, ovf_err;
  logic [11:0] launch_index;
  logic [CW-1:0] launch_argc;
  logic [DEPTH*32-1:0] launch_args;
  logic [31:0] arr_dirty;

  mthd_front #(.ARG_DEPTH(DEPTH)) u_mthd_front (
    .clk(clk), .rst_n(rst_n), .call_valid(call_valid), .call_method(call_method),
    .call_arg(call_arg), .call_remain(call_remain), .dirty_clr(dirty_clr),
    .rd_method(rd_method), .rd_data(rd_data), .launch_valid(launch_valid),
    .launch_index(launch_index), .launch_argc(launch_argc), .launch_args(launch_args),
    .fmt_dirty(fmt_dirty), .arr_dirty(arr_dirty), .proto_err(proto_err), .ovf_err(ovf_err));

  int checks = 0, fails = 0, cyc = 0;

  // Behavioural reference state
  logic [31:0] m_regs [int];
  logic [31:0] m_args [$];
  logic [31:0] e_args [$];
  bit m_exec; int m_cur;
  bit e_lv, e_fmt, e_perr, e_ovf; int e_idx, e_argc;
  logic [31:0] e_arr;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mread(int a);
    if (a < 288 && m_regs.exists(a)) return m_regs[a];
    return 32'h0;
  endfunction

  task automatic model_reset();
    m_regs.delete(); m_args.delete(); e_args.delete();
    m_exec = 0; m_cur = 0; e_lv = 0; e_fmt = 0; e_perr = 0; e_ovf = 0; e_arr = 0;
    e_idx = 0; e_argc = 0;
  endtask

  task automatic model_step(bit v, int m, logic [31:0] a, int rem, bit clr);
    e_lv = 0;
    if (clr) begin e_arr = 0; e_fmt = 0; end
    if (!v) return;
    if (m >= 'hE00) begin
      if (!m_exec && (m % 2) == 1) e_perr = 1;
      else begin
        if (!m_exec) begin m_exec = 1; m_cur = m; end
        else if (m != m_cur + 1) e_perr = 1;
        if (m_args.size() < DEPTH) m_args.push_back(a); else e_ovf = 1;
        if (rem <= 1) begin
          e_lv = 1; e_idx = (m_cur - 'hE00) / 2; e_argc = m_args.size();
          e_args = m_args; m_args.delete(); m_exec = 0;
        end
      end
    end else begin
      if (m_exec) e_perr = 1;
      if (m < 288 && mread(m) != a) begin
        m_regs[m] = a;
        if (m >= 16 && m < 32) e_fmt = 1;
        if (m >= 64 && m < 192) e_arr[(m - 64) / 4] = 1;
        else if (m >= 192 && m < 256) e_arr[(m - 192) / 2] = 1;
        else if (m >= 256 && m < 288) e_arr[m - 256] = 1;
      end
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "launch_valid", launch_valid, e_lv);
    if (e_lv) begin
      chk(tag, "launch_index", launch_index, e_idx);
      chk(tag, "launch_argc", launch_argc, e_argc);
      foreach (e_args[k]) chk(tag, "launch_arg", launch_args[k*32 +: 32], e_args[k]);
    end
    chk(tag, "fmt_dirty", fmt_dirty, e_fmt);
    chk(tag, "arr_dirty", arr_dirty, e_arr);
    chk(tag, "proto_err", proto_err, e_perr);
    chk(tag, "ovf_err", ovf_err, e_ovf);
  endtask

  task automatic cycle(bit v, int m, logic [31:0] a, int rem, bit clr, string tag);
    call_valid = v; call_method = m[12:0]; call_arg = a; call_remain = rem[15:0]; dirty_clr = clr;
    @(posedge clk); @(negedge clk);
    model_step(v, m, a, rem, clr);
    compare(tag);
    call_valid = 0; dirty_clr = 0;
  endtask

  task automatic wr(int m, logic [31:0] a, string tag);
    cycle(1, m, a, 1, 0, tag);
  endtask

  task automatic rd(int m, string tag);
    rd_method = m[12:0]; #1;
    chk(tag, "rd_data", rd_data, mread(m));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; call_valid = 0; dirty_clr = 0;
    @(posedge clk); @(negedge clk); rst_n = 1;
    model_reset();
    compare("R1");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    rd(0, "R1"); rd('h44, "R1"); rd('h11F, "R1");
    // R12 format window and R8 equal-value write
    wr('h12, 32'h5, "R12");
    cycle(1, 0, 0, 0, 1, "R13");
    wr('h12, 32'h5, "R8");
    rd('h12, "R8");
    wr('h1F, 32'h9, "R12");
    cycle(0, 0, 0, 0, 1, "R13");
    // R9 descriptor window ends
    wr('h44, 32'h7, "R9"); wr('hBC, 32'h1, "R9"); wr('h47, 32'h3, "R9");
    cycle(0, 0, 0, 0, 1, "R13");
    // R10 limit window ends
    wr('hC3, 32'h2, "R10"); wr('hFE, 32'h4, "R10");
    cycle(0, 0, 0, 0, 1, "R13");
    // R11 instanced window ends
    wr('h100, 32'h8, "R11"); wr('h11F, 32'h6, "R11");
    // R8 writing the reset value changes nothing
    wr('h50, 32'h0, "R8");
    // R14 beyond the file
    wr('h120, 32'hAB, "R14"); wr('h500, 32'hCD, "R14");
    rd('h120, "R14"); rd('h500, "R14");
    // R13 clear with a same-cycle change
    cycle(1, 'h48, 32'h11, 1, 1, "R13");
    // R7 setup: ordinary register 0
    wr(0, 32'h55, "R8");
    rd(0, "R8");
    // R3 / R2 three-word macro
    cycle(1, 'hE04, 32'hA0, 3, 0, "R3");
    cycle(1, 'hE05, 32'hA1, 2, 0, "R3");
    cycle(1, 'hE05, 32'hA2, 1, 0, "R3");
    cycle(0, 0, 0, 0, 0, "R3");
    // R6 back-to-back single-word launches, remain 1 and 0
    cycle(1, 'hE10, 32'hB0, 1, 0, "R6");
    cycle(1, 'hE02, 32'hB1, 0, 0, "R6");
    // R7 macro call at 0xE00 leaves register 0 and dirty state alone
    cycle(1, 'hE00, 32'h77, 1, 0, "R7");
    rd(0, "R7");
    // R5 overflow
    cycle(1, 'hE06, 32'hC0, 6, 0, "R5");
    for (int k = 1; k < 6; k++) cycle(1, 'hE07, 32'hC0 + k, 6 - k, 0, "R5");
    cycle(0, 0, 0, 0, 0, "R5");
    // R2 odd start on a fresh block
    do_reset();
    cycle(1, 'hE03, 32'hD0, 1, 0, "R2");
    cycle(0, 0, 0, 0, 0, "R2");
    // R4 wrong argument method, and an ordinary write mid-call
    do_reset();
    cycle(1, 'hE08, 32'hE0, 3, 0, "R4");
    cycle(1, 'h13, 32'hE1, 1, 0, "R4");
    rd('h13, "R4");
    cycle(1, 'hE0A, 32'hE2, 1, 0, "R4");
    cycle(0, 0, 0, 0, 0, "R4");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule